// File: doc/BRIEF.md
# DRAM Distributed Refresh Controller

This block keeps the contents of a DRAM array alive. It issues one row refresh at a fixed interval, so that the refreshes for the whole array are spread across the retention window and do not arrive as one long burst. A free-running interval timer adds one refresh to an owed count on every period. An arbiter starts an owed refresh at the next idle point of the memory bus. It never cuts into a host access that is in progress, except when the owed count has reached its ceiling. While a refresh occupies the bus, host requests are held off.

A row counter names the row to refresh and steps forward after every finished refresh. A mode input picks how the refresh reaches the device. In address mode the controller drives the row counter onto the row address lines during the refresh. In counter mode it raises only the refresh strobe and leaves the address lines undriven at zero, because the device keeps its own row count. In counter mode a refresh may also be hidden: it is overlapped with an ongoing host access and does not hold the host off. A refresh never uses a column address or the data bus.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset the interval timer, the row counter and the owed count are zero. host_gnt, ref_cmd, ref_busy and row_oe are low, and row_addr is zero.
- R2: The timer wraps every INTERVAL cycles and adds one owed refresh each time it wraps. With no host traffic, ref_cmd first rises at the (INTERVAL+1)-th rising edge after reset is released.
- R3: Each refresh holds ref_cmd high for exactly REF_CYCLES consecutive cycles. At least one idle cycle separates two refreshes.
- R4: The row counter advances by one when a refresh finishes and wraps from ROWS-1 to 0.
- R5: When mode_ext is 1, row_oe is high and row_addr carries the row counter for the whole of a refresh. When mode_ext is 0, row_oe is low and row_addr is zero.
- R6: If a refresh is owed while a host access is active, the refresh waits. ref_cmd rises two edges after host_req falls: one edge ends the grant, and the next starts the refresh.
- R7: The host is granted only when no refresh is running and none is owed. host_gnt then rises one edge after host_req. The grant stays high while host_req stays high.
- R8: The owed count saturates at MAX_OWED. When the count reaches MAX_OWED, host_gnt is withdrawn on the next edge even if host_req stays high, and the host is not granted again until the count is zero.
- R9: When mode_ext is 0 and hide_en is 1, an owed refresh starts during an active host access. ref_cmd is high and host_gnt stays high during that refresh.
- R10: ref_busy equals ref_cmd for a refresh started from an idle bus and stays low for a hidden refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ext | input | 1 | 1: drive the row address during refresh; 0: strobe only, device counts rows |
| hide_en | input | 1 | Allow refreshes to overlap host accesses (counter mode only) |
| host_req | input | 1 | Host requests the memory bus; held high for the access |
| host_gnt | output | 1 | Host owns the memory bus |
| ref_cmd | output | 1 | Refresh strobe to the device |
| ref_busy | output | 1 | Memory is blocked by a refresh |
| row_oe | output | 1 | Row address lines driven by the controller |
| row_addr | output | ROW_W | Row to refresh (address mode) |

## Verification
Every output comes straight from registers, so each result appears one edge after the cycle that causes it. A host grant shows one edge after the request. A refresh strobe shows one edge after the timer wraps on an idle bus, or two edges after the host releases the bus. The strobe falls REF_CYCLES edges after it rises, and the row counter steps on the same edge. The bench drives inputs on falling edges. It advances its reference model on the rising edges and compares every output on the next falling edge, so each expected value is sampled in exactly the cycle in which the design must produce it.

// File: rtl/drc_pkg.sv
package drc_pkg;
   typedef struct packed {
      logic active;
      logic hidden;
   } ref_state_t;
endpackage

// File: rtl/drc_interval_timer.sv
module drc_interval_timer #(
   parameter int INTERVAL = 1039
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
   localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

   generate
      if (INTERVAL < 2) begin : g_bad_interval
         $error("INTERVAL must be at least 2");
      end
   endgenerate

   logic [TW-1:0] count_q;

   assign tick = (count_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)    count_q <= '0;
      else if (tick) count_q <= '0;
      else           count_q <= count_q + 1'b1;
   end

   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (count_q == '0));
endmodule

// File: rtl/drc_row_counter.sv
module drc_row_counter #(
   parameter int ROW_W = 13,
   parameter int ROWS  = 8192
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [ROW_W-1:0] row
);
   localparam logic [ROW_W-1:0] TOP = ROW_W'(ROWS - 1);

   generate
      if (ROWS < 2 || ROWS > (1 << ROW_W)) begin : g_bad_rows
         $error("ROWS must lie in 2 .. 2**ROW_W");
      end
   endgenerate

   logic [ROW_W-1:0] row_q;
   logic [ROW_W-1:0] row_next;

   generate
      if (ROWS == (1 << ROW_W)) begin : g_pow2
         assign row_next = row_q + 1'b1;
      end else begin : g_mod
         assign row_next = (row_q == TOP) ? '0 : row_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   row_q <= '0;
      else if (adv) row_q <= row_next;
   end

   assign row = row_q;

   assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && row_q != TOP) |=> (row_q == $past(row_q) + 1'b1));
   assert_row_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && row_q == TOP) |=> (row_q == '0));
   assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(row_q));
endmodule

// File: rtl/drc_arbiter.sv
module drc_arbiter
   import drc_pkg::*;
#(
   parameter int REF_CYCLES = 4,
   parameter int MAX_OWED   = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       host_req,
   input  logic       hide_en,
   input  logic       mode_ext,
   output logic       host_act,
   output ref_state_t ref_st,
   output logic       ref_done
);
   localparam int CW = (REF_CYCLES > 1) ? $clog2(REF_CYCLES) : 1;
   localparam int OW = $clog2(MAX_OWED + 1);
   localparam logic [CW-1:0] CLAST = CW'(REF_CYCLES - 1);
   localparam logic [OW-1:0] OMAX  = OW'(MAX_OWED);

   generate
      if (REF_CYCLES < 1) begin : g_bad_len
         $error("REF_CYCLES must be at least 1");
      end
      if (MAX_OWED < 1) begin : g_bad_owed
         $error("MAX_OWED must be at least 1");
      end
   endgenerate

   logic [OW-1:0] owed_q;
   logic [CW-1:0] cyc_q;
   logic          act_q, hid_q, host_q;
   logic          urgent, hide_ok, start, done;

   assign urgent  = (owed_q == OMAX);
   assign hide_ok = host_q && hide_en && !mode_ext;
   assign done    = act_q && (cyc_q == CLAST);
   assign start   = !act_q && (owed_q != '0) && (!host_q || hide_ok);

   // owed refresh count: +1 on tick, -1 on start, saturating at the ceiling
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owed_q <= '0;
      end else begin
         case ({tick, start})
            2'b10:   owed_q <= urgent ? owed_q : owed_q + 1'b1;
            2'b01:   owed_q <= owed_q - 1'b1;
            default: owed_q <= owed_q;
         endcase
      end
   end

   // refresh in progress
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         hid_q <= 1'b0;
         cyc_q <= '0;
      end else if (start) begin
         act_q <= 1'b1;
         hid_q <= host_q;
         cyc_q <= '0;
      end else if (done) begin
         act_q <= 1'b0;
         hid_q <= 1'b0;
         cyc_q <= '0;
      end else if (act_q) begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   // host ownership of the bus
   always_ff @(posedge clk) begin
      if (!rst_n)      host_q <= 1'b0;
      else if (host_q) host_q <= host_req && !urgent;
      else             host_q <= host_req && !act_q && !start;
   end

   assign host_act      = host_q;
   assign ref_st.active = act_q;
   assign ref_st.hidden = hid_q;
   assign ref_done      = done;

   assert_owed_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (urgent && tick && !start) |=> (owed_q == OMAX));
   assert_start_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (act_q && cyc_q == '0));
   assert_end_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !act_q);
   assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !hid_q) |-> !host_q);
   assert_hide_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && host_q) |-> (hide_en && !mode_ext));
   assert_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_q && urgent) |=> !host_q);
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
   import drc_pkg::*;
#(
   parameter int INTERVAL   = 1039,
   parameter int REF_CYCLES = 4,
   parameter int MAX_OWED   = 8,
   parameter int ROW_W      = 13,
   parameter int ROWS       = 8192
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_ext,
   input  logic             hide_en,
   input  logic             host_req,
   output logic             host_gnt,
   output logic             ref_cmd,
   output logic             ref_busy,
   output logic             row_oe,
   output logic [ROW_W-1:0] row_addr
);
   generate
      if (INTERVAL <= REF_CYCLES + 1) begin : g_bad_budget
         $error("INTERVAL must exceed REF_CYCLES + 1");
      end
   endgenerate

   logic             tick;
   logic             host_act;
   logic             done;
   ref_state_t       st;
   logic [ROW_W-1:0] row;

   drc_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   drc_arbiter #(.REF_CYCLES(REF_CYCLES), .MAX_OWED(MAX_OWED)) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .host_req (host_req),
      .hide_en  (hide_en),
      .mode_ext (mode_ext),
      .host_act (host_act),
      .ref_st   (st),
      .ref_done (done)
   );

   drc_row_counter #(.ROW_W(ROW_W), .ROWS(ROWS)) u_rows (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (done),
      .row   (row)
   );

   assign host_gnt = host_act;
   assign ref_cmd  = st.active;
   assign ref_busy = st.active && !st.hidden;
   assign row_oe   = st.active && mode_ext;
   assign row_addr = row_oe ? row : '0;

   assert_oe_needs_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      row_oe |-> ref_cmd);
   assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ref_busy |-> !host_gnt);
endmodule

// File: tb/dram_refresh_ctrl_test.sv
module dram_refresh_ctrl_test;
   localparam int IV = 20, RC = 4, MO = 8, RW = 4, NR = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic mode_ext = 1'b1, hide_en = 1'b0, host_req = 1'b0;
   logic host_gnt, ref_cmd, ref_busy, row_oe;
   logic [RW-1:0] row_addr;

   int checks = 0, fails = 0;
   string phase = "R2";

   always #2 clk = ~clk;

   dram_refresh_ctrl #(.INTERVAL(IV), .REF_CYCLES(RC), .MAX_OWED(MO),
                       .ROW_W(RW), .ROWS(NR)) uut (
      .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .hide_en(hide_en),
      .host_req(host_req), .host_gnt(host_gnt), .ref_cmd(ref_cmd),
      .ref_busy(ref_busy), .row_oe(row_oe), .row_addr(row_addr));

   // behavioural reference model
   int m_timer = 0, m_cnt = 0, m_owed = 0, m_row = 0;
   bit m_act = 0, m_hid = 0, m_host = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_timer = 0; m_cnt = 0; m_owed = 0; m_row = 0;
         m_act = 0; m_hid = 0; m_host = 0;
      end else begin
         bit tk, fin, st, n_host;
         tk  = (m_timer == IV - 1);
         fin = m_act && (m_cnt == RC - 1);
         st  = !m_act && (m_owed > 0) && (!m_host || (hide_en && !mode_ext));
         if (m_host) n_host = host_req && (m_owed != MO);
         else        n_host = host_req && !m_act && !st;
         m_timer = tk ? 0 : m_timer + 1;
         if (tk && m_owed < MO) m_owed++;
         if (st) m_owed--;
         if (fin) m_row = (m_row + 1) % NR;
         if (st) begin
            m_act = 1; m_hid = m_host; m_cnt = 0;
         end else if (fin) begin
            m_act = 0; m_hid = 0; m_cnt = 0;
         end else if (m_act) m_cnt++;
         m_host = n_host;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s (%s) at %0t: actual %0d expected %0d", tag, phase, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("host_gnt R7", int'(host_gnt), int'(m_host));
         chk("ref_cmd R3", int'(ref_cmd), int'(m_act));
         chk("ref_busy R10", int'(ref_busy), int'(m_act && !m_hid));
         chk("row_oe R5", int'(row_oe), int'(m_act && mode_ext));
         chk("row_addr R4", int'(row_addr), (m_act && mode_ext) ? m_row : 0);
      end
   end

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1: reset state, sampled before the first active edge
      chk("R1 host_gnt", int'(host_gnt), 0);
      chk("R1 ref_cmd", int'(ref_cmd), 0);
      chk("R1 row_addr", int'(row_addr), 0);
      // R2: first strobe at edge IV+1
      idle(IV);
      chk("R2 no strobe yet", int'(ref_cmd), 0);
      idle(1);
      chk("R2 first strobe", int'(ref_cmd), 1);
      // R4 wrap over many refreshes in address mode
      phase = "R4 R5";
      idle(NR * IV + 60);
      // R6 R7: short host accesses
      phase = "R6 R7";
      for (int k = 0; k < 30; k++) begin
         host_req = 1'b1; idle(7);
         host_req = 1'b0; idle(3);
      end
      // R8: host holds the bus long enough to reach the ceiling
      phase = "R8";
      idle(10);
      host_req = 1'b1; idle(IV * (MO + 3));
      host_req = 1'b0; idle(IV * 4);
      // R9: hidden refresh in counter mode
      phase = "R9 R10";
      mode_ext = 1'b0; hide_en = 1'b1;
      host_req = 1'b1; idle(IV * 6);
      host_req = 1'b0; idle(IV * 2);
      // counter mode without hiding: R6 wait behaviour
      phase = "R5 R6";
      hide_en = 1'b0;
      for (int k = 0; k < 12; k++) begin
         host_req = 1'b1; idle(13);
         host_req = 1'b0; idle(2);
      end
      idle(IV * 3);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #400000;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule